// File: doc/BRIEF.md
# LED Tug-of-War Reaction Game

A two-player reaction game played on an 8-LED bar. After reset the bar runs a short light show. Then a single lit marker appears in the middle of the bar. After a randomized wait, a go indicator lights on the lowest LED. The first player to press after go pulls the marker one step toward their own end of the bar. When the marker reaches either end, the bar flashes the winner's half and the game freezes until the next reset.

The block is driven by the system clock, an asynchronous active-low reset and two active-low player buttons. It drives the 8-bit LED vector directly. The buttons are assumed to be debounced and synchronized already. The light-show interval, the fixed part of the wait and the width of the random part are all parameters in clock cycles. The random part comes from a 16-bit LFSR that is reloaded at the start of every wait with a seed tied to the marker position.

Top module: `tug_game`

## Requirements
- R1: While reset is held, led is 0x01. After release, led shows 1<<k for k = 0..7, each value held for BLINK cycles.
- R2: After the walk, led shows 0x00, 0xFF, 0x00, 0xFF, each held for BLINK cycles. The first round then starts.
- R3: The first round starts with the marker at 0x10. During every wait, led equals the marker with bit 0 clear.
- R4: A wait lasts BASE_WAIT + r + 1 cycles, where r is the low RAND_BITS bits of the LFSR after BASE_WAIT steps from the seed. The seed is SEED_BASE + i*SEED_STEP (low 16 bits), with i the bit index of the marker. One LFSR step shifts left and feeds s[15]^s[13]^s[12]^s[10] into bit 0.
- R5: After the wait, led equals the marker with bit 0 set (go).
- R6: While go is lit, btn_n = 2'b10 (btn_n[0] low only) moves the marker one bit up, and btn_n = 2'b01 moves it one bit down. In both cases the next cycle shows the new marker with go cleared and a new wait begins.
- R7: Button presses during a wait do not move the marker and do not end the wait early.
- R8: While go is lit, btn_n = 2'b00 is not accepted: go stays lit and the marker stays put.
- R9: When the marker reaches 0x02, led alternates 0x0E and 0x00, four times each, each value held for BLINK cycles.
- R10: When the marker reaches 0x80, led alternates 0xE0 and 0x00 in the same way.
- R11: After either winner flash, led stays 0x00 and the buttons have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 2 | Player buttons, active low; bit 0 pulls the marker up, bit 1 pulls it down |
| led | output | 8 | LED bar; bit 0 is the go indicator |

## Verification
The bench computes every wait length from the LFSR rule and the seed of each marker position. A design that seeds from the wrong position, or is off by one in the base or random count, shows go a cycle early or late and fails. Buttons are pressed throughout waits: a design that accepts early presses moves the marker before go. Both buttons are held low together while go is lit: a design that treats that as a press from either player moves the marker. After each winner flash the buttons are pressed again: a design that does not freeze leaves the all-off display.

// File: rtl/tug_game.sv
module tug_game #(
  parameter int BLINK     = 12_000_000,
  parameter int BASE_WAIT = 24_000_000,
  parameter int RAND_BITS = 16,
  parameter int SEED_BASE = 16'hACE1,
  parameter int SEED_STEP = 16'h0F0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] btn_n,
  output logic [7:0] led
);
  localparam int CMAX = (BLINK > BASE_WAIT) ? BLINK : BASE_WAIT;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_WALK, S_FLASH, S_WAITB, S_WAITR, S_GO, S_WIN, S_HALT} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [3:0]           step;
  logic [7:0]           mk;
  logic [15:0]          lfsr;
  logic [RAND_BITS-1:0] rem;
  logic                 up_win;

  function automatic logic [15:0] seed_of(input logic [7:0] m);
    logic [31:0] t;
    t = 32'(SEED_BASE);
    for (int i = 0; i < 8; i++)
      if (m[i]) t = 32'(SEED_BASE + i * SEED_STEP);
    return t[15:0];
  endfunction

  wire        blink_end = (cnt == CW'(BLINK - 1));
  wire [15:0] lfsr_nx   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  wire        press     = (st == S_GO) && (btn_n == 2'b10 || btn_n == 2'b01);
  wire [7:0]  mk_nx     = (btn_n == 2'b10) ? (mk << 1) : (mk >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WALK;
      cnt    <= '0;
      step   <= '0;
      mk     <= 8'h10;
      lfsr   <= 16'h0001;
      rem    <= '0;
      up_win <= 1'b0;
    end else begin
      case (st)
        S_WALK, S_FLASH, S_WIN: begin
          if (blink_end) begin
            cnt  <= '0;
            step <= step + 4'd1;
            if (st == S_WALK && step == 4'd7) begin
              st   <= S_FLASH;
              step <= '0;
            end else if (st == S_FLASH && step == 4'd3) begin
              st   <= S_WAITB;
              step <= '0;
              lfsr <= seed_of(mk);
            end else if (st == S_WIN && step == 4'd7) begin
              st <= S_HALT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAITB: begin
          lfsr <= lfsr_nx;
          if (cnt == CW'(BASE_WAIT - 1)) begin
            cnt <= '0;
            rem <= lfsr_nx[RAND_BITS-1:0];
            st  <= S_WAITR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAITR: begin
          if (rem == '0) st <= S_GO;
          else           rem <= rem - 1'b1;
        end
        S_GO: begin
          if (press) begin
            mk <= mk_nx;
            if (mk_nx == 8'h80 || mk_nx == 8'h02) begin
              st     <= S_WIN;
              up_win <= mk_nx[7];
              cnt    <= '0;
              step   <= '0;
            end else begin
              st   <= S_WAITB;
              cnt  <= '0;
              lfsr <= seed_of(mk_nx);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_WALK:           led = 8'h01 << step[2:0];
      S_FLASH:          led = step[0] ? 8'hFF : 8'h00;
      S_WAITB, S_WAITR: led = mk;
      S_GO:             led = mk | 8'h01;
      S_WIN:            led = step[0] ? 8'h00 : (up_win ? 8'hE0 : 8'h0E);
      default:          led = 8'h00;
    endcase
  end

  // R3
  marker_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mk) == 1);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITB || st == S_WAITR) |=> $stable(mk));

  // R8
  both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GO && btn_n == 2'b00) |=> (st == S_GO && $stable(mk)));

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GO && btn_n == 2'b10) |=> (mk == ($past(mk) << 1) && !led[0]));

  // R9
  win_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GO && btn_n == 2'b01 && mk == 8'h04) |=> (led == 8'h0E));

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT) |=> (st == S_HALT && led == 8'h00));
endmodule

// File: tb/test_tug_game.sv
module test_tug_game;
  localparam int B  = 3;
  localparam int W  = 5;
  localparam int RB = 3;
  localparam int SB = 16'hACE1;
  localparam int SS = 16'h0F0F;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] btn_n;
  logic [7:0] led;
  int ncmp = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  tug_game #(.BLINK(B), .BASE_WAIT(W), .RAND_BITS(RB), .SEED_BASE(SB), .SEED_STEP(SS))
    i_tug_game (.clk(clk), .rst_n(rst_n), .btn_n(btn_n), .led(led));

  task automatic chk(input logic [7:0] exp, input string req);
    ncmp++;
    if (led !== exp) begin
      nbad++;
      $display("FAIL %s: led=%h expected %h", req, led, exp);
    end
  endtask

  function automatic int rnd_of(input logic [7:0] m);
    int idx = 0;
    logic [31:0] t;
    logic [15:0] s;
    for (int i = 0; i < 8; i++) if (m[i]) idx = i;
    t = 32'(SB + idx * SS);
    s = t[15:0];
    for (int i = 0; i < W; i++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    return int'(s) % (1 << RB);
  endfunction

  task automatic do_reset_intro();
    rst_n = 1'b0;
    btn_n = 2'b11;
    repeat (3) @(negedge clk);
    chk(8'h01, "R1 reset");
    rst_n = 1'b1;
    for (int k = 0; k < 8 * B; k++) begin
      chk(8'h01 << (k / B), "R1 walk");
      @(negedge clk);
    end
    for (int k = 0; k < 4 * B; k++) begin
      chk(((k / B) % 2) ? 8'hFF : 8'h00, "R2 flash");
      @(negedge clk);
    end
  endtask

  task automatic wait_go(input logic [7:0] m, input bit noise);
    int n = W + rnd_of(m) + 1;
    for (int i = 0; i < n; i++) begin
      chk(m, noise ? "R7 wait with presses" : "R4 wait length");
      if (noise) btn_n = (i % 2) ? 2'b10 : 2'b01;
      @(negedge clk);
    end
    btn_n = 2'b11;
    chk(m | 8'h01, "R5 go");
  endtask

  task automatic take(input logic [7:0] m, input logic [1:0] b, input bit both);
    logic [7:0] nm;
    if (both) begin
      for (int i = 0; i < 2; i++) begin
        btn_n = 2'b00;
        @(negedge clk);
        chk(m | 8'h01, "R8 both low");
      end
    end
    btn_n = b;
    @(negedge clk);
    btn_n = 2'b11;
    nm = (b == 2'b10) ? (m << 1) : (m >> 1);
    if (nm == 8'h02 || nm == 8'h80) begin
      for (int k = 0; k < 8 * B; k++) begin
        chk(((k / B) % 2) ? 8'h00 : ((nm == 8'h80) ? 8'hE0 : 8'h0E),
            (nm == 8'h80) ? "R10 up win" : "R9 down win");
        @(negedge clk);
      end
      for (int k = 0; k < 12; k++) begin
        chk(8'h00, "R11 halt");
        btn_n = (k % 3 == 0) ? 2'b10 : ((k % 3 == 1) ? 2'b01 : 2'b00);
        @(negedge clk);
      end
      btn_n = 2'b11;
    end else begin
      chk(nm, "R6 step");
    end
  endtask

  initial begin
    btn_n = 2'b11;
    do_reset_intro();
    chk(8'h10, "R3 start");
    wait_go(8'h10, 1'b1); take(8'h10, 2'b10, 1'b1);
    wait_go(8'h20, 1'b0); take(8'h20, 2'b01, 1'b0);
    wait_go(8'h10, 1'b1); take(8'h10, 2'b01, 1'b0);
    wait_go(8'h08, 1'b0); take(8'h08, 2'b01, 1'b1);
    wait_go(8'h04, 1'b1); take(8'h04, 2'b01, 1'b0);
    do_reset_intro();
    chk(8'h10, "R3 start");
    wait_go(8'h10, 1'b0); take(8'h10, 2'b10, 1'b0);
    wait_go(8'h20, 1'b1); take(8'h20, 2'b10, 1'b1);
    wait_go(8'h40, 1'b0); take(8'h40, 2'b10, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule